// File: doc/BRIEF.md
# Write-only cross-clock command queue

This block moves byte-wide commands from a processor clock domain into a video pixel-clock domain that runs at an unrelated frequency. The processor sees a small window of write-only locations. A store to any of them pushes one entry, which holds the data byte and the low address bits that picked the location. So the address can serve as a command opcode while the byte carries its operand. The processor never waits for a reply. It only has to keep from overrunning the queue. A full flag and a sticky overflow flag give it what it needs for that.

On the video side, a valid flag reports a pending entry. The entry's data and location bits are presented directly, and a one-cycle pop strobe consumes it. The queue holds 16 entries by default. This lets a burst of stores land at the processor's own rate, while each pointer update takes the usual two-flop synchronizer delay to reach the other domain. Each side has its own asynchronous reset.

Top module: `cmd_xfifo`

## Requirements
- R1: After both resets are released and before any write, `valid_o`, `full_o` and `overflow_o` are all 0.
- R2: Entries reach the video side in the order they were accepted, each with the same `rd_data_o` byte and `rd_addr_o` location bits that were presented on `wr_data_i` and `wr_addr_i` at the write.
- R3: With nothing popped, 16 writes are all accepted. Once the queue settles, `full_o` is 0 after 15 writes and 1 after the 16th.
- R4: A write while `full_o` is 1 is discarded and sets `overflow_o` from the next write-clock cycle. `overflow_o` then stays 1 until `wrst_ni` is asserted, which clears it.
- R5: `valid_o` is 1 exactly when an entry is pending. A `pop_i` pulse while `valid_o` is 0 has no effect: the next entry written is still the next one delivered.
- R6: An entry written into an empty queue raises `valid_o` within four read-clock cycles after the write edge.
- R7: After entries are popped, `full_o` drops again and the queue keeps correct order across any number of pointer wrap-arounds, for every burst length from 1 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Processor-side clock |
| wrst_ni | input | 1 | Processor-side asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe into the location window |
| wr_addr_i | input | ADDR_W | Low address bits of the written location |
| wr_data_i | input | 8 | Command byte |
| full_o | output | 1 | No room for another entry |
| overflow_o | output | 1 | Sticky: a write was discarded while full |
| rclk_i | input | 1 | Video-side clock |
| rrst_ni | input | 1 | Video-side asynchronous reset, active low |
| pop_i | input | 1 | Consume the presented entry |
| valid_o | output | 1 | An entry is presented |
| rd_data_o | output | 8 | Presented command byte |
| rd_addr_o | output | ADDR_W | Presented location bits |

## Verification
The assertions assume that each pointer crosses domains only as a registered Gray code, and that the full and empty decisions rest only on synchronized copies. They also assume that `pop_i` and `wr_en_i` are synchronous to their own clocks and last one cycle per transfer. The stimulus drives every strobe on the falling edge of its own clock. The write and read clocks have coprime periods, so the crossing phase drifts through all alignments. The bench stores only while `full_o` is low, except for the one deliberate overflow store, and pops only while `valid_o` is high, except for the deliberate empty pops.

// File: rtl/cmd_xfifo_pkg.sv
package cmd_xfifo_pkg;
  localparam int unsigned CMD_DATA_W = 8;
  typedef logic [CMD_DATA_W-1:0] cmd_byte_t;
endpackage

// File: rtl/cmd_xfifo_sync.sv
module cmd_xfifo_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cmd_xfifo_mem.sv
module cmd_xfifo_mem #(
  parameter int unsigned EW    = 10,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read is combinational; the slot is stable while it is visible as pending
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cmd_xfifo_wside.sv
module cmd_xfifo_wside #(
  parameter int unsigned PW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [PW:0] rgray_sync_i,
  output logic [PW:0] wgray_o,
  output logic [PW-1:0] waddr_o,
  output logic        wr_ok_o,
  output logic        full_o,
  output logic        overflow_o
);
  logic [PW:0] wbin_q, wbin_d, wgray_q;
  logic        ovf_q;

  // full: Gray pointers differ in the two top bits only
  assign full_o  = (wgray_q == {~rgray_sync_i[PW:PW-1], rgray_sync_i[PW-2:0]});
  assign wr_ok_o = wr_en_i & ~full_o;
  assign wbin_d  = wbin_q + {{PW{1'b0}}, wr_ok_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      ovf_q   <= ovf_q | (wr_en_i & full_o);
    end
  end

  assign wgray_o    = wgray_q;
  assign waddr_o    = wbin_q[PW-1:0];
  assign overflow_o = ovf_q;

  // R3
  wr_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $stable(wbin_q));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R4
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> overflow_o);
  // R6
  wgray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/cmd_xfifo_rside.sv
module cmd_xfifo_rside #(
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [PW:0]   wgray_sync_i,
  output logic [PW:0]   rgray_o,
  output logic [PW-1:0] raddr_o,
  output logic          valid_o
);
  logic [PW:0] rbin_q, rbin_d, rgray_q;
  logic        rd_ok;

  assign valid_o = (rgray_q != wgray_sync_i);
  assign rd_ok   = pop_i & valid_o;
  assign rbin_d  = rbin_q + {{PW{1'b0}}, rd_ok};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
    end
  end

  assign rgray_o = rgray_q;
  assign raddr_o = rbin_q[PW-1:0];

  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && pop_i) |=> $stable(rbin_q));
  // R5
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pop_i) |=> (rbin_q == $past(rbin_q) + 1'b1));
  // R6
  rgray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/cmd_xfifo.sv
module cmd_xfifo
  import cmd_xfifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              full_o,
  output logic              overflow_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [7:0]        rd_data_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned EW = ADDR_W + CMD_DATA_W;

  logic [PW:0]   wgray, rgray, wgray_rs, rgray_ws;
  logic [PW-1:0] waddr, raddr;
  logic          wr_ok;
  logic [EW-1:0] rentry;
  cmd_byte_t     wbyte;

  assign wbyte = wr_data_i;

  cmd_xfifo_wside #(.PW(PW)) u_wside (
    .clk_i       (wclk_i),
    .rst_ni      (wrst_ni),
    .wr_en_i     (wr_en_i),
    .rgray_sync_i(rgray_ws),
    .wgray_o     (wgray),
    .waddr_o     (waddr),
    .wr_ok_o     (wr_ok),
    .full_o      (full_o),
    .overflow_o  (overflow_o)
  );

  cmd_xfifo_sync #(.W(PW+1)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(wrst_ni),
    .d_i   (rgray),
    .q_o   (rgray_ws)
  );

  cmd_xfifo_sync #(.W(PW+1)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (wgray),
    .q_o   (wgray_rs)
  );

  cmd_xfifo_mem #(.EW(EW), .DEPTH(DEPTH)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_ok),
    .waddr_i(waddr),
    .wdata_i({wr_addr_i, wbyte}),
    .raddr_i(raddr),
    .rdata_o(rentry)
  );

  cmd_xfifo_rside #(.PW(PW)) u_rside (
    .clk_i       (rclk_i),
    .rst_ni      (rrst_ni),
    .pop_i       (pop_i),
    .wgray_sync_i(wgray_rs),
    .rgray_o     (rgray),
    .raddr_o     (raddr),
    .valid_o     (valid_o)
  );

  assign rd_data_o = rentry[CMD_DATA_W-1:0];
  assign rd_addr_o = rentry[EW-1:CMD_DATA_W];

  initial begin
    // R3
    depth_cfg_chk: assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0);
  end
endmodule

// File: tb/tb_cmd_xfifo.sv
module tb_cmd_xfifo;
  localparam int AW = 2;
  localparam int DEPTH = 16;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_en = 1'b0, pop = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic full, overflow, valid;
  logic [7:0] rd_data;
  logic [AW-1:0] rd_addr;

  int checks = 0, failures = 0;
  logic [9:0] exp_q [1024];
  int widx = 0, ridx = 0;
  bit done = 0;

  always #2 wclk = ~wclk;   // 250 MHz
  always #3.5 rclk = ~rclk; // unrelated video clock

  cmd_xfifo #(.ADDR_W(AW), .DEPTH(DEPTH)) dut (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .full_o(full), .overflow_o(overflow),
    .rclk_i(rclk), .rrst_ni(rrst_n), .pop_i(pop), .valid_o(valid),
    .rd_data_o(rd_data), .rd_addr_o(rd_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  // one store; recorded as expected only if accepted
  task automatic put(input logic [AW-1:0] a, input logic [7:0] d, input bit wait_room);
    @(negedge wclk);
    if (wait_room) while (full) @(negedge wclk);
    if (!full) begin
      exp_q[widx % 1024] = {a, d};
      widx++;
    end
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic take(input string req);
    int n = 0;
    @(negedge rclk);
    while (!valid && n < 200) begin @(negedge rclk); n++; end
    if (!valid) begin
      chk(0, req, 0, 1);
    end else begin
      chk({rd_addr, rd_data} == exp_q[ridx % 1024], req,
          int'({rd_addr, rd_data}), int'(exp_q[ridx % 1024]));
      ridx++;
      pop = 1'b1;
      @(negedge rclk);
      pop = 1'b0;
    end
  endtask

  initial begin
    #20000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge wclk);
    wrst_n = 1'b1; rrst_n = 1'b1;
    settle();
    // R1 reset state
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

    // R3 fill without popping, sweeping all location codes
    for (int i = 0; i < DEPTH; i++) begin
      put(AW'(i % 4), 8'((i * 17 + 3) % 256), 1'b0);
      if (i == DEPTH - 2) begin
        settle();
        chk(full == 1'b0, "R3 not full at 15", int'(full), 0);
      end
    end
    settle();
    chk(full == 1'b1, "R3 full at 16", int'(full), 1);
    chk(overflow == 1'b0, "R3 no overflow", int'(overflow), 0);

    // R4 store while full is dropped and flags overflow
    put(2'd3, 8'hEE, 1'b0);
    chk(overflow == 1'b1, "R4 overflow set", int'(overflow), 1);

    // R2 drain in order with location bits
    for (int i = 0; i < DEPTH; i++) take("R2 order");
    settle();
    chk(valid == 1'b0, "R5 empty after drain", int'(valid), 0);
    chk(full == 1'b0, "R7 room after drain", int'(full), 0);

    // R5 pops while empty are ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge rclk); pop = 1'b1;
      @(negedge rclk); pop = 1'b0;
      chk(valid == 1'b0, "R5 empty pop", int'(valid), 0);
    end

    // R6 latency into empty queue
    begin
      int n = 0;
      put(2'd2, 8'h5A, 1'b0);
      @(negedge rclk); n = 1;
      while (!valid && n < 10) begin @(negedge rclk); n++; end
      chk(n <= 4, "R6 latency", n, 4);
    end
    take("R5 entry after empty pops");

    // R7 every burst length, crossing many wraps
    for (int k = 1; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) put(AW'((i + k) % 4), 8'((k * 31 + i * 7) % 256), 1'b1);
      for (int i = 0; i < k; i++) take("R7 burst");
    end
    settle();
    chk(valid == 1'b0, "R7 empty after bursts", int'(valid), 0);
    chk(overflow == 1'b1, "R4 overflow sticky", int'(overflow), 1);

    // R2 concurrent producer and consumer with stalls on full
    fork
      for (int i = 0; i < 200; i++) begin
        put(AW'(i % 4), 8'((i * 13 + 1) % 256), 1'b1);
        if (i % 37 == 0) repeat (5) @(negedge wclk);
      end
      for (int i = 0; i < 200; i++) begin
        take("R2 streaming");
        if (i % 11 == 0) repeat (20) @(negedge rclk);
      end
    join
    chk(ridx == widx, "R2 count", ridx, widx);
    // R7 both pointer counts must meet after streaming
    settle();
    chk(valid == 1'b0 && full == 1'b0, "R7 idle after stream", int'({valid, full}), 0);

    // R4 write reset clears overflow
    wrst_n = 1'b0; rrst_n = 1'b0;
    repeat (3) @(negedge wclk);
    wrst_n = 1'b1; rrst_n = 1'b1;
    settle();
    chk(overflow == 1'b0, "R4 overflow cleared", int'(overflow), 0);
    chk(valid == 1'b0, "R1 valid after reset", int'(valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule